// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter. It drives a trial code into an external DAC, reads back one comparator decision per step, and resolves the result from the most significant bit down. The sample-and-hold, comparator, DAC, reference and input multiplexer are outside the block. It drives their controls (sample strobe, channel code, reference code, power enable) and receives only the comparator bit.

Software works through four byte-wide registers. A control register holds the enable, start, interrupt-enable and completion flag bits. A selection register holds the channel, the reference and the result alignment. Two result registers hold the low and high bytes. A prescaler divides the system clock into step ticks. A conversion spends one tick period sampling and then one tick period on each of the ten bits. At the end the result registers update in one cycle, the completion flag is set and, if allowed, an interrupt request is raised.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads zero, `dac_code` is 0, and `sample_hold`, `ana_en` and `irq` are low.
- R2: With an ideal comparator (`cmp_in` high when the input is at or above the DAC output), the result equals the input level clamped to 1023. Ground gives 0 and any level at or above full scale gives 1023.
- R3: The trial code starts at 512 (bit 9 only). Each step sets the next lower bit on top of the bits kept so far and keeps it when `cmp_in` is high, down to bit 0.
- R4: With `STEP_DIV` = D, `sample_hold` is high for D cycles from the start write, each of the ten steps lasts D cycles, and `irq` rises exactly 11·D clock edges after the start write.
- R5: The completion flag (control bit 4, address 0) is set when a conversion ends. Writing 1 to that bit clears it and writing 0 leaves it set. `irq` equals the flag ANDed with interrupt enable (control bit 3).
- R6: A write of the start bit (control bit 6) is ignored unless the same write also sets enable (control bit 7). No sampling, no trial code and no flag follow it.
- R7: The start bit reads 1 from the start write until the conversion completes, then reads 0.
- R8: Addresses 2 and 3 read the low and high result bytes. With the left-adjust bit (selection bit 6) clear, the high byte is {6'b0, result[9:8]} and the low byte is result[7:0]. With it set, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R9: `ana_chan` and `ana_ref` follow the selection register fields (channel bits 3:0, where 0–7 are input pins, 8 is the bandgap and 9 is ground; reference bits 5:4, where 0 is the external pin, 1 is the supply and 2 is the internal 1.1 V reference) only while enabled. While disabled they hold their last applied values.
- R10: Clearing enable during a conversion stops it. The block returns to idle with `dac_code` 0, `sample_hold` low and start reading 0, and the flag is not set.
- R11: The result registers keep their previous value during a conversion and change only in the cycle the conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address (0 control, 1 selection, 2 result low, 3 result high) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| cmp_in | input | 1 | Comparator decision: 1 when the held input is at or above the DAC output |
| dac_code | output | 10 | Trial code for the DAC, 0 when not stepping |
| sample_hold | output | 1 | High while the input is being sampled |
| ana_en | output | 1 | Power enable for the analog side |
| ana_chan | output | 4 | Applied channel code |
| ana_ref | output | 2 | Applied reference code |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
The assertions assume that `cmp_in` is settled and stable at each step-tick edge, and that `STEP_DIV` is at least 2 so that ticks never fall on adjacent cycles. The bench drives `cmp_in` combinationally from a modelled integer input level and the current `dac_code`, so the comparator answer is always settled well before the next edge. The bench issues register writes only at falling edges, one at a time, and never writes start while a conversion is running.

// File: rtl/sar_pkg.sv
// Shared definitions for the successive-approximation controller.
// Assumes: register addresses are two bits wide.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_STEP   = 2'd2
    } sar_state_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_SEL   = 2'd1;
    localparam logic [1:0] ADDR_RESLO = 2'd2;
    localparam logic [1:0] ADDR_RESHI = 2'd3;

    // Bit positions inside the control register
    localparam int CTRL_EN   = 7;
    localparam int CTRL_GO   = 6;
    localparam int CTRL_FLAG = 4;
    localparam int CTRL_IE   = 3;
    // Bit position of the alignment option inside the selection register
    localparam int SEL_LEFT  = 6;
endpackage

// File: rtl/sar_prescaler.sv
// Step-tick generator: emits a one-cycle tick every DIV cycles while run is high.
// Assumes: DIV >= 2. The counter is held at zero while idle, so it does not toggle.
module sar_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Tick on the last count of each period
    always_comb tick = run && (cnt == LAST);

    // Count while running, wrap on the tick, clear while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + CW'(1);
    end

    // R4: a tick is never followed straight away by another one
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sar_engine.sv
// Successive-approximation sequencer: a sample phase, then one trial per bit from MSB to LSB.
// Assumes: cmp_in is settled at every tick edge. A low enable aborts at once.
// start is a one-cycle request that is only asserted while enable is high.
module sar_engine
    import sar_pkg::*;
#(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             tick,
    input  logic             cmp_in,
    output logic             busy,
    output logic             sample_hold,
    output logic [NBITS-1:0] dac_code,
    output logic             done,
    output logic [NBITS-1:0] result
);
    localparam int IW = $clog2(NBITS);
    localparam logic [IW-1:0] TOP_IDX = IW'(NBITS - 1);

    sar_state_t       state;
    logic [IW-1:0]    idx;
    logic [NBITS-1:0] acc;
    logic [NBITS-1:0] trial;
    logic [NBITS-1:0] decided;

    // Trial bit for the current step, and the accumulator after this step's decision
    always_comb begin
        trial   = NBITS'(1) << idx;
        decided = cmp_in ? (acc | trial) : acc;
    end

    // Outputs decoded from the sequencer state
    always_comb begin
        busy        = (state != ST_IDLE);
        sample_hold = (state == ST_SAMPLE);
        dac_code    = (state == ST_STEP) ? (acc | trial) : '0;
        done        = (state == ST_STEP) && tick && (idx == '0);
    end

    // Sequencer: idle, sample, then step through the bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            acc    <= '0;
            result <= '0;
        end else if (!enable) begin
            state <= ST_IDLE;
            idx   <= '0;
            acc   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_SAMPLE;
                    acc   <= '0;
                end
                ST_SAMPLE: if (tick) begin
                    state <= ST_STEP;
                    idx   <= TOP_IDX;
                end
                ST_STEP: if (tick) begin
                    acc <= decided;
                    if (idx == '0) begin
                        state  <= ST_IDLE;
                        result <= decided;
                    end else begin
                        idx <= idx - IW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: a low enable leaves the sequencer idle on the next cycle
    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_IDLE));
    // R3: the first trial after sampling is the MSB alone
    a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_SAMPLE && tick) |=> (dac_code == (NBITS'(1) << (NBITS - 1))));
    // R11: the result only changes on the completing step
    a_r11_result_atomic: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(result));
endmodule

// File: rtl/sar_regfile.sv
// Byte-wide register file: control, selection and the two result bytes, plus the analog select latches.
// Assumes: at most one write per cycle. result changes only on done.
module sar_regfile
    import sar_pkg::*;
#(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             busy,
    input  logic             done,
    input  logic [NBITS-1:0] result,
    output logic             en_d,
    output logic             start_o,
    output logic             en_q,
    output logic [3:0]       ana_chan,
    output logic [1:0]       ana_ref,
    output logic             irq
);
    localparam int PAD = 16 - NBITS;

    logic       ie_q, flag_q, left_q;
    logic [3:0] chan_q;
    logic [1:0] ref_q;
    logic       wr_ctrl, wr_sel;
    logic [15:0] aligned;

    // Write decode, next enable value and start request
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_sel  = reg_wr && (reg_addr == ADDR_SEL);
        en_d    = wr_ctrl ? reg_wdata[CTRL_EN] : en_q;
        start_o = wr_ctrl && reg_wdata[CTRL_GO] && reg_wdata[CTRL_EN] && !busy;
    end

    // Control bits and completion flag (set wins over a write-one clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            en_q <= en_d;
            if (wr_ctrl) ie_q <= reg_wdata[CTRL_IE];
            if (done)                                 flag_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[CTRL_FLAG]) flag_q <= 1'b0;
        end
    end

    // Selection fields as written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            ref_q  <= '0;
            left_q <= 1'b0;
        end else if (wr_sel) begin
            chan_q <= reg_wdata[3:0];
            ref_q  <= reg_wdata[5:4];
            left_q <= reg_wdata[SEL_LEFT];
        end
    end

    // Selections reach the analog side only while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ana_chan <= '0;
            ana_ref  <= '0;
        end else if (en_q) begin
            ana_chan <= chan_q;
            ana_ref  <= ref_q;
        end
    end

    // Result alignment across the two bytes
    always_comb begin
        if (left_q) aligned = {result, {PAD{1'b0}}};
        else        aligned = {{PAD{1'b0}}, result};
    end

    // Read multiplexer
    always_comb begin
        case (reg_addr)
            ADDR_CTRL:  reg_rdata = {en_q, busy, 1'b0, flag_q, ie_q, 3'b000};
            ADDR_SEL:   reg_rdata = {1'b0, left_q, ref_q, chan_q};
            ADDR_RESLO: reg_rdata = aligned[7:0];
            default:    reg_rdata = aligned[15:8];
        endcase
    end

    always_comb irq = flag_q && ie_q;

    // R5: a completed conversion leaves the flag set
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag_q);
    // R9: applied selections hold while disabled
    a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> ($stable(ana_chan) && $stable(ana_ref)));
    // R6: no start request can leave while the next enable is low
    a_r6_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_d |-> !start_o);
endmodule

// File: rtl/sar_adc_ctrl.sv
// Top of the successive-approximation controller: register file, prescaler and sequencer.
// Assumes: the external comparator is settled within one step period. STEP_DIV >= 2.
module sar_adc_ctrl #(
    parameter int NBITS    = 10,
    parameter int STEP_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             cmp_in,
    output logic [NBITS-1:0] dac_code,
    output logic             sample_hold,
    output logic             ana_en,
    output logic [3:0]       ana_chan,
    output logic [1:0]       ana_ref,
    output logic             irq
);
    logic             en_d, en_q, start, busy, tick, done;
    logic [NBITS-1:0] result;

    sar_regfile #(.NBITS(NBITS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .result(result),
        .en_d(en_d), .start_o(start), .en_q(en_q),
        .ana_chan(ana_chan), .ana_ref(ana_ref), .irq(irq)
    );

    sar_prescaler #(.DIV(STEP_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    sar_engine #(.NBITS(NBITS)) u_engine (
        .clk(clk), .rst_n(rst_n), .enable(en_d), .start(start), .tick(tick),
        .cmp_in(cmp_in), .busy(busy), .sample_hold(sample_hold),
        .dac_code(dac_code), .done(done), .result(result)
    );

    always_comb ana_en = en_q;

    // R10: with the analog side powered down, nothing drives the DAC or samples
    a_r10_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ana_en |-> (dac_code == '0 && !sample_hold));
endmodule

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
    localparam int DIV = 4;
    localparam int NB  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cmp_in;
    logic [NB-1:0] dac_code;
    logic       sample_hold, ana_en, irq;
    logic [3:0] ana_chan;
    logic [1:0] ana_ref;

    int vin = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    assign cmp_in = (vin >= int'(dac_code));

    sar_adc_ctrl #(.NBITS(NB), .STEP_DIV(DIV)) i_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .sample_hold(sample_hold), .ana_en(ana_en),
        .ana_chan(ana_chan), .ana_ref(ana_ref), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Driver: queue the expected trial codes, start, time the completion, check the result
    task automatic convert(input int level, input logic left);
        int acc = 0;
        int n = 0;
        int expr;
        logic [7:0] lo, hi, c;
        vin = level;
        for (int b = NB - 1; b >= 0; b--) begin
            exp_q.push_back(acc | (1 << b));
            if (level >= (acc | (1 << b))) acc = acc | (1 << b);
        end
        expr = (level > 1023) ? 1023 : level;
        wr(2'd1, {1'b0, left, 6'b0});
        wr(2'd0, 8'hC8);               // enable, start, interrupt enable
        chk(sample_hold == 1'b1, "R4 sampling after start", sample_hold, 1);
        while (!irq && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == 11 * DIV, "R4 completion edge count", n, 11 * DIV);
        rd(2'd0, c);
        chk(c[6] == 1'b0, "R7 start clear after completion", c[6], 0);
        chk(c[4] == 1'b1, "R5 flag set", c[4], 1);
        rd(2'd2, lo);
        rd(2'd3, hi);
        if (left) chk({hi, lo} == 16'(expr << 6), "R8 R2 left-adjusted result", {hi, lo}, expr << 6);
        else      chk({hi, lo} == 16'(expr), "R8 R2 right-adjusted result", {hi, lo}, expr);
        wr(2'd0, 8'h98);               // clear flag, keep enable and interrupt enable
        chk(irq == 1'b0, "R5 irq low after write-one clear", irq, 0);
    endtask

    // Monitor: after sampling ends, compare each trial code against the queue
    initial begin
        forever begin
            @(negedge sample_hold);
            @(negedge clk);
            if (dac_code != '0) begin
                for (int k = 0; k < NB; k++) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected trial", dac_code, -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(int'(dac_code) == e, "R3 trial code", dac_code, e);
                    end
                    if (k < NB - 1) repeat (DIV) @(negedge clk);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] d, lo0, hi0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk(d == 8'h00, "R1 register reset", d, 0);
        end
        chk(dac_code == '0 && !sample_hold && !ana_en && !irq, "R1 outputs reset",
            {dac_code, sample_hold, ana_en, irq}, 0);

        // R9: selections held while disabled
        wr(2'd1, 8'h25);               // channel 5, reference internal 1.1 V
        repeat (2) @(negedge clk);
        chk(ana_chan == 4'd0 && ana_ref == 2'd0, "R9 selection held while disabled",
            {ana_ref, ana_chan}, 0);

        // R6: start without enable is ignored
        wr(2'd0, 8'h48);
        repeat (3 * DIV) @(negedge clk);
        chk(!sample_hold && dac_code == '0, "R6 no activity", {sample_hold, dac_code}, 0);
        rd(2'd0, d);
        chk(d[6] == 1'b0 && d[4] == 1'b0, "R6 start and flag stay clear", d, 0);

        // R9: selections applied once enabled
        wr(2'd0, 8'h88);
        repeat (2) @(negedge clk);
        chk(ana_chan == 4'd5 && ana_ref == 2'd2, "R9 selection applied", {ana_ref, ana_chan}, 8'h25);
        wr(2'd1, 8'h09);               // ground channel, external reference
        repeat (2) @(negedge clk);
        chk(ana_chan == 4'd9 && ana_ref == 2'd0, "R9 selection follows", {ana_ref, ana_chan}, 9);

        // R2, R3, R4, R5, R8: conversions across levels and alignments
        convert(700, 1'b0);
        convert(0, 1'b0);
        convert(1023, 1'b1);
        convert(2000, 1'b0);
        convert(512, 1'b1);
        convert(511, 1'b0);
        convert(341, 1'b1);

        // R5: writing zero to the flag leaves it set; irq follows interrupt enable
        convert(100, 1'b0);
        wr(2'd0, 8'h88);               // no-op on state
        vin = 200;
        exp_q.push_back(512); exp_q.push_back(256); exp_q.push_back(128);
        exp_q.push_back(192); exp_q.push_back(224); exp_q.push_back(208);
        exp_q.push_back(200); exp_q.push_back(204); exp_q.push_back(202);
        exp_q.push_back(201);
        wr(2'd0, 8'hC0);               // start with interrupt disabled
        // R7 and R11: start reads one, result unchanged mid-conversion
        repeat (3 * DIV) @(negedge clk);
        rd(2'd0, d);
        chk(d[6] == 1'b1, "R7 start reads one while busy", d[6], 1);
        rd(2'd2, lo0);
        rd(2'd3, hi0);
        chk({hi0, lo0} == 16'd100, "R11 previous result during conversion", {hi0, lo0}, 100);
        repeat (12 * DIV) @(negedge clk);
        chk(irq == 1'b0, "R5 irq masked", irq, 0);
        rd(2'd0, d);
        chk(d[4] == 1'b1, "R5 flag set with irq masked", d[4], 1);
        wr(2'd0, 8'h80);               // write zero to the flag bit
        rd(2'd0, d);
        chk(d[4] == 1'b1, "R5 write zero keeps flag", d[4], 1);
        wr(2'd0, 8'h88);
        chk(irq == 1'b1, "R5 irq follows enable", irq, 1);
        wr(2'd0, 8'h98);
        rd(2'd2, lo0);
        chk(lo0 == 8'd200, "R2 result 200", lo0, 200);

        // R10: abort during the sample phase
        wr(2'd0, 8'hC8);
        chk(sample_hold == 1'b1, "R10 sampling before abort", sample_hold, 1);
        wr(2'd0, 8'h08);
        chk(!sample_hold && dac_code == '0 && !ana_en, "R10 idle after abort",
            {sample_hold, dac_code, ana_en}, 0);
        repeat (12 * DIV) @(negedge clk);
        rd(2'd0, d);
        chk(d[6] == 1'b0 && d[4] == 1'b0, "R10 no start, no flag after abort", d, 0);
        chk(exp_q.size() == 0, "R3 all trials observed", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule